// File: doc/BRIEF.md
# Mains-Synchronous Inverter Period Controller

This block closes the digital loop that keeps an inverter in step with the utility supply. Once per mains cycle a measurement front end hands it two numbers in timer ticks: the length of the last mains cycle and the signed phase offset between the mains and the inverter output. From these the block produces the period the inverter should run for its next cycle. The phase offset passes through a proportional-plus-integral filter whose output is scaled and added to the measured mains period.

Tracking happens only while the measured mains period lies in an acceptable window. Outside it the loop is switched off. The integrator is flushed and the block steers back to a fixed nominal period of 400 ticks, one 50 Hz cycle at 50 us per tick. Every new period is confined to an absolute band and may differ from the previous one by only a few ticks. A separate bypass-permission flag rises only after the phase offset has stayed small for eight samples in a row.

Samples enter on a valid/ready stream, and results leave on one. An input is taken only when `in_valid` and `in_ready` are both high on a clock edge. `in_ready` is high whenever the output slot is empty or is being drained in the same cycle. A result stays on `out_period` with `out_valid` high until the consumer raises `out_ready`. The bypass flag is a plain level output that changes only when a sample is taken.

Top module: `period_track_ctrl`

## Requirements
- R1: After reset `out_period` is 400, `out_valid` is 0, `bypass_ok` is 0 and `in_ready` is 1.
- R2: A sample with `in_period` from 380 to 420 inclusive is tracked. For any other sample the target is 400, the integrator is cleared, the lock count returns to zero, and `bypass_ok` is 0 after that sample.
- R3: For a tracked sample with phase error e, the integrator becomes sat(I + (e >>> 4), -64, +64). The target is `in_period` + (((e >>> 2) + new I) >>> 1). Here >>> is an arithmetic right shift on two's-complement values.
- R4: A tracked target is clamped into the band 385 to 415 ticks.
- R5: Each accepted sample moves `out_period` toward its target by at most 4 ticks.
- R6: `bypass_ok` is 1 after the eighth consecutive tracked sample with |e| < 4. It stays 1 while such samples continue. Any sample that fails this condition clears it.
- R7: `out_period`, `bypass_ok` and the loop state change only on an accepted sample. A sample that is offered while `in_ready` is 0 has no effect.
- R8: `in_ready` = !`out_valid` || `out_ready`. `out_valid` is set by an accepted sample and cleared by a handshake that brings no new sample. While `out_valid` is 1 and `out_ready` is 0, `out_period` holds.
- R9: The integrator saturates at ±64, so a long run of large errors adds at most 64 to the filter output. This keeps the loop from winding up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Sample can be taken this cycle |
| in_period | input | W | Measured mains period in ticks |
| in_phase | input | W | Signed phase error in ticks, two's complement |
| out_valid | output | 1 | New period result waiting |
| out_ready | input | 1 | Consumer takes the result |
| out_period | output | W | Inverter period for the next cycle |
| bypass_ok | output | 1 | Transfer to bypass permitted |

## Verification
Two events can fall on the same clock edge: draining one result and accepting the next sample. In that case the output register must be overwritten with the new result and not cleared. The bench provokes this by streaming samples back to back with `out_ready` held high. The scoreboard must then see one result per sample, in order, with no gaps and no duplicates. A second collision is also exercised: the integrator saturating, the band clamp and the step limiter all acting on the same sample. This happens under a sustained large phase error, and each result is judged against an independently computed model.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  localparam int CW = 24;
  typedef logic signed [CW-1:0] calc_t;

  function automatic calc_t sat(calc_t v, calc_t lo, calc_t hi);
    if (v < lo) return lo;
    if (v > hi) return hi;
    return v;
  endfunction

  function automatic calc_t mag(calc_t v);
    return (v < 0) ? -v : v;
  endfunction
endpackage

// File: rtl/ptc_pi_filter.sv
module ptc_pi_filter
  import ptc_pkg::*;
#(
  parameter int KP_SH   = 2,
  parameter int KI_SH   = 4,
  parameter int KO_SH   = 1,
  parameter int INT_LIM = 64
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  track,
  input  calc_t err,
  output calc_t corr
);
  localparam calc_t LIM = calc_t'(INT_LIM);

  calc_t integ_q, integ_nx;

  always_comb begin
    integ_nx = sat(integ_q + (err >>> KI_SH), -LIM, LIM);
    corr     = ((err >>> KP_SH) + integ_nx) >>> KO_SH;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  integ_q <= '0;
    else if (en) integ_q <= track ? integ_nx : '0;
  end

  // R9: the accumulator never leaves its band
  a_r9_integ_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (integ_q <= LIM) && (integ_q >= -LIM));
  // R2: an untracked sample flushes the accumulator
  a_r2_integ_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !track) |=> (integ_q == '0));
endmodule

// File: rtl/ptc_period_limiter.sv
module ptc_period_limiter
  import ptc_pkg::*;
#(
  parameter int W       = 16,
  parameter int NOMINAL = 400,
  parameter int OUT_LO  = 385,
  parameter int OUT_HI  = 415,
  parameter int STEP    = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         track,
  input  logic [W-1:0] in_period,
  input  calc_t        corr,
  output logic [W-1:0] period
);
  localparam calc_t LO  = calc_t'(OUT_LO);
  localparam calc_t HI  = calc_t'(OUT_HI);
  localparam calc_t NOM = calc_t'(NOMINAL);
  localparam calc_t STP = calc_t'(STEP);

  calc_t cur_q, target, delta, nxt;

  always_comb begin
    target = track ? sat(calc_t'({{(CW-W){1'b0}}, in_period}) + corr, LO, HI) : NOM;
    delta  = sat(target - cur_q, -STP, STP);
    nxt    = cur_q + delta;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  cur_q <= NOM;
    else if (en) cur_q <= nxt;
  end

  assign period = cur_q[W-1:0];

  // R4: the held period stays inside the band spanned by the limits and nominal
  a_r4_band: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_q >= ((LO < NOM) ? LO : NOM)) && (cur_q <= ((HI > NOM) ? HI : NOM)));
endmodule

// File: rtl/ptc_lock_detect.sv
module ptc_lock_detect
  import ptc_pkg::*;
#(
  parameter int LOCK_TH  = 4,
  parameter int LOCK_CYC = 8
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  en,
  input  logic  track,
  input  calc_t err,
  output logic  bypass_ok
);
  localparam int CNTW = (LOCK_CYC > 1) ? $clog2(LOCK_CYC) : 1;
  localparam logic [CNTW-1:0] TOP = CNTW'(LOCK_CYC - 1);

  logic [CNTW-1:0] cnt_q;
  logic            qual;

  assign qual = track && (mag(err) < calc_t'(LOCK_TH));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      bypass_ok <= 1'b0;
    end else if (en) begin
      if (qual) begin
        cnt_q     <= (cnt_q == TOP) ? cnt_q : cnt_q + 1'b1;
        bypass_ok <= (cnt_q == TOP);
      end else begin
        cnt_q     <= '0;
        bypass_ok <= 1'b0;
      end
    end
  end

  // R6: permission only moves on a taken sample
  a_r6_bypass_steady: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(bypass_ok));
  // R2: an out-of-window sample withdraws permission
  a_r2_bypass_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !track) |=> !bypass_ok);
endmodule

// File: rtl/period_track_ctrl.sv
module period_track_ctrl
  import ptc_pkg::*;
#(
  parameter int W        = 16,
  parameter int NOMINAL  = 400,
  parameter int MAINS_LO = 380,
  parameter int MAINS_HI = 420,
  parameter int OUT_LO   = 385,
  parameter int OUT_HI   = 415,
  parameter int STEP     = 4,
  parameter int KP_SH    = 2,
  parameter int KI_SH    = 4,
  parameter int KO_SH    = 1,
  parameter int INT_LIM  = 64,
  parameter int LOCK_TH  = 4,
  parameter int LOCK_CYC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_period,
  input  logic [W-1:0] in_phase,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_period,
  output logic         bypass_ok
);
  logic  fire, in_window;
  calc_t err, corr;

  assign in_ready  = !out_valid || out_ready;
  assign fire      = in_valid && in_ready;
  assign in_window = (in_period >= W'(MAINS_LO)) && (in_period <= W'(MAINS_HI));
  assign err       = calc_t'({{(CW-W){in_phase[W-1]}}, in_phase});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         out_valid <= 1'b0;
    else if (fire)      out_valid <= 1'b1;
    else if (out_ready) out_valid <= 1'b0;
  end

  ptc_pi_filter #(.KP_SH(KP_SH), .KI_SH(KI_SH), .KO_SH(KO_SH), .INT_LIM(INT_LIM)) u_filt (
    .clk(clk), .rst_n(rst_n), .en(fire), .track(in_window), .err(err), .corr(corr));

  ptc_period_limiter #(.W(W), .NOMINAL(NOMINAL), .OUT_LO(OUT_LO), .OUT_HI(OUT_HI),
                       .STEP(STEP)) u_lim (
    .clk(clk), .rst_n(rst_n), .en(fire), .track(in_window), .in_period(in_period),
    .corr(corr), .period(out_period));

  ptc_lock_detect #(.LOCK_TH(LOCK_TH), .LOCK_CYC(LOCK_CYC)) u_lock (
    .clk(clk), .rst_n(rst_n), .en(fire), .track(in_window), .err(err),
    .bypass_ok(bypass_ok));

  // R5: slew bound on each update
  a_r5_step_limit: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (((out_period >= $past(out_period)) ? (out_period - $past(out_period))
                                                 : ($past(out_period) - out_period))
              <= W'(STEP)));
  // R7: period frozen without a taken sample
  a_r7_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> $stable(out_period));
  // R8: a stalled result is neither dropped nor altered
  a_r8_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_period)));
  // R8: a taken sample always produces a result
  a_r8_fire_valid: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> out_valid);
endmodule

// File: tb/test_period_track_ctrl.sv
`timescale 1ns/1ps
module test_period_track_ctrl;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [W-1:0] in_period = '0;
  logic [W-1:0] in_phase = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [W-1:0] out_period;
  logic         bypass_ok;

  always #2.5 clk = ~clk;

  period_track_ctrl i_period_track_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_period(in_period), .in_phase(in_phase), .out_valid(out_valid),
    .out_ready(out_ready), .out_period(out_period), .bypass_ok(bypass_ok));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int exp_per_q[$];
  int exp_byp_q[$];
  string tag_q[$];

  // reference model state
  int m_per = 400, m_integ = 0, m_cnt = 0;

  function automatic int clampi(int v, int lo, int hi);
    return (v < lo) ? lo : ((v > hi) ? hi : v);
  endfunction

  task automatic check(bit ok, string req, string what, int got, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic model_push(int p, int e, string tag);
    int tgt, corr, byp;
    if (p >= 380 && p <= 420) begin
      m_integ = clampi(m_integ + (e >>> 4), -64, 64);
      corr    = ((e >>> 2) + m_integ) >>> 1;
      tgt     = clampi(p + corr, 385, 415);
      if (e < 4 && e > -4) begin
        byp   = (m_cnt >= 7) ? 1 : 0;
        m_cnt = (m_cnt >= 7) ? 7 : m_cnt + 1;
      end else begin
        byp = 0; m_cnt = 0;
      end
    end else begin
      m_integ = 0; m_cnt = 0; byp = 0; tgt = 400;
    end
    m_per = m_per + clampi(tgt - m_per, -4, 4);
    exp_per_q.push_back(m_per);
    exp_byp_q.push_back(byp);
    tag_q.push_back(tag);
  endtask

  task automatic send(int p, int e, string tag);
    @(negedge clk);
    in_valid  = 1'b1;
    in_period = W'(p);
    in_phase  = W'(e);
    while (!in_ready) @(negedge clk);
    model_push(p, e, tag);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // monitor: pop and compare on each output handshake
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_per_q.size() == 0) begin
        check(1'b0, "R8", "unexpected result", int'(out_period), -1);
      end else begin
        int ep, eb;
        string t;
        ep = exp_per_q.pop_front();
        eb = exp_byp_q.pop_front();
        t  = tag_q.pop_front();
        check(int'(out_period) == ep, t, "out_period", int'(out_period), ep);
        check(int'(bypass_ok) == eb, t, "bypass_ok (R6)", int'(bypass_ok), eb);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: got stalled run expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int held;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(out_period == 16'd400, "R1", "reset out_period", int'(out_period), 400);
    check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
    check(bypass_ok == 1'b0, "R1", "reset bypass_ok", int'(bypass_ok), 0);
    check(in_ready == 1'b1, "R1", "reset in_ready", int'(in_ready), 1);
    @(posedge clk); #1 rst_n = 1'b1;

    // R6 lock qualification with small errors, back-to-back (drain + accept same edge)
    for (int i = 0; i < 10; i++) send(400, (i % 2 == 0) ? 3 : -3, "R6");
    // R6 error equal to threshold breaks lock
    send(401, 4, "R6");
    send(401, 0, "R6");

    // R3 R4 R5 R9 sustained large positive then negative error
    for (int i = 0; i < 10; i++) send(410, 200, "R9");
    for (int i = 0; i < 14; i++) send(390, -200, "R3");
    send(405, 17, "R3");
    send(395, -9, "R3");

    // R2 out of window both sides, and inclusive edges
    for (int i = 0; i < 4; i++) send(421, 0, "R2");
    for (int i = 0; i < 3; i++) send(379, -50, "R2");
    for (int i = 0; i < 5; i++) send(380, 0, "R4");
    for (int i = 0; i < 9; i++) send(420, 1, "R2");
    send(300, 1, "R2");

    // R7 R8 back-pressure
    @(posedge clk); #1 out_ready = 1'b0;
    send(402, 0, "R8");
    @(negedge clk);
    check(out_valid == 1'b1, "R8", "valid held under stall", int'(out_valid), 1);
    check(in_ready == 1'b0, "R8", "in_ready low under stall", int'(in_ready), 0);
    held = int'(out_period);
    in_valid = 1'b1; in_period = W'(415); in_phase = W'(300);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(int'(out_period) == held, "R7", "period under refused sample", int'(out_period), held);
      check(out_valid == 1'b1, "R8", "valid while stalled", int'(out_valid), 1);
    end
    in_valid = 1'b0;
    @(posedge clk); #1 out_ready = 1'b1;
    // refused sample must not have moved loop state
    send(402, 0, "R7");
    @(posedge clk);
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "valid cleared after drain", int'(out_valid), 0);
    check(exp_per_q.size() == 0, "R8", "results outstanding", exp_per_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule